// File: doc/BRIEF.md
# Periodic Comparator Timer Channel

This block is one event channel of a multi-channel high-resolution timer. A shared free-running counter value comes in every cycle. The channel compares that value with its own comparator and produces a single-cycle interrupt pulse when the counter reaches the comparator. Software programs the channel through write strobes for a 32-bit configuration word and for the low and high halves of the comparator. The current configuration and comparator values are always visible on the readback outputs.

The channel has two operating modes. In one-shot mode the comparator stays where software put it. In periodic mode the channel keeps a hidden period register and adds the period to the comparator after each event, so events repeat. A narrow mode restricts the comparator, the period and the comparison to 32 bits. In narrow one-shot mode, a target that lies numerically below the counter is treated as a target after the next wrap of the counter's low half.

The global enable gates everything the channel does on its own. While it is low, only register writes have any effect. Address decoding, interrupt routing and the counter itself belong to the surrounding timer.

Top module: `ptimer_chan`

## Requirements
- R1: After reset, `cfg_o` reads 0x0000_0030, `cmp_o` is all ones and `irq_o` is low. A comparator holding the 64-bit all-ones value never raises an interrupt.
- R2: A configuration write changes only these bits: 2 (interrupt enable), 3 (periodic), 6 (set-value), 8 (narrow) and 9 to 14 (stored only). Bit 4 (periodic-capable) and bit 5 (wide-capable) always read 1. Every other bit, including bit 1 (level type, unsupported), always reads 0.
- R3: Writing the narrow bit 8 as 1 clears the upper 32 bits of the comparator and of the period. In narrow mode, writes to the comparator's high half are ignored.
- R4: A comparator-half write in one-shot mode, or in periodic mode with bit 6 set, loads that comparator half. In periodic mode a low-half write also loads the period low half; in narrow mode bit 31 of that value is cleared. In periodic mode with bit 6 clear, a high-half write loads only the period high half, with bit 63 cleared.
- R5: Any comparator-half write clears bit 6 of the configuration.
- R6: In periodic mode, whenever the signed distance (comparator minus counter, at the active width) is zero or negative and the period is nonzero, the comparator advances by the period once per cycle until it is ahead of the counter. In narrow mode the addition wraps modulo 2^32.
- R7: An interrupt fires when the signed distance first becomes zero or negative after a comparator or configuration write, or after the previous event. In one-shot mode a target already behind the counter fires at once, and the comparator never changes.
- R8: In narrow one-shot mode, a low-half write whose value is below the counter's low 32 bits (unsigned) sets a hidden wrap flag. While the flag is set, no interrupt fires. The flag clears once the counter's low half is below the comparator again, and the event fires on the following match.
- R9: `irq_o` can be high only if configuration bit 2 was set and `gen_i` was high at the deciding clock edge. While `gen_i` is low the channel neither advances nor fires.
- R10: `irq_o` is a one-cycle pulse. It rises right after the clock edge at which `cnt_i` first meets the comparator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | 64 | Current main counter value |
| gen_i | input | 1 | Global enable of the timer |
| cfg_we_i | input | 1 | Configuration write strobe |
| cmp_lo_we_i | input | 1 | Comparator low-half write strobe |
| cmp_hi_we_i | input | 1 | Comparator high-half write strobe |
| wdata_i | input | 32 | Write data for all strobes |
| cfg_o | output | 32 | Configuration readback |
| cmp_o | output | 64 | Comparator readback |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The hidden period register shows at the ports one cycle after the first periodic event, because the new comparator equals the old comparator plus that period. A wrong period or a missing MSB clamp therefore shows up as a wrong `cmp_o` right after the event. A wrong wrap flag or a stale previous-due bit shows up as a pulse on `irq_o` that comes one cycle early, comes twice, or does not come at all. The stimulus places the counter exactly on, just before and far past the comparator to expose these faults.

// File: rtl/ptimer_pkg.sv
`timescale 1ns/1ps
package ptimer_pkg;
  localparam int CFG_LEVEL    = 1;
  localparam int CFG_INT_EN   = 2;
  localparam int CFG_PERIODIC = 3;
  localparam int CFG_PER_CAP  = 4;
  localparam int CFG_WIDE_CAP = 5;
  localparam int CFG_SETVAL   = 6;
  localparam int CFG_NARROW   = 8;
  localparam logic [31:0] CFG_WMASK   = 32'h0000_7F4C;
  localparam logic [31:0] CFG_RO_ONES = 32'h0000_0030;
endpackage

// File: rtl/ptimer_cfg.sv
`timescale 1ns/1ps
module ptimer_cfg
  import ptimer_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  input  logic        clr_setval_i,
  output logic [31:0] cfg_o
);
  logic [31:0] cfg_q, cfg_d;
  logic        cfg_en;

  assign cfg_en = we_i | clr_setval_i;

  always_comb begin
    cfg_d = cfg_q;
    if (we_i) cfg_d = (wdata_i & CFG_WMASK) | CFG_RO_ONES;
    if (clr_setval_i) cfg_d[CFG_SETVAL] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= CFG_RO_ONES;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/ptimer_dist.sv
`timescale 1ns/1ps
module ptimer_dist #(
  parameter int WW = 32
) (
  input  logic [2*WW-1:0] cmp_i,
  input  logic [2*WW-1:0] cnt_i,
  input  logic            narrow_i,
  output logic            due_o
);
  localparam int CW = 2 * WW;
  logic [CW-1:0] d_wide;
  logic [WW-1:0] d_narrow;
  logic          parked;

  assign d_wide   = cmp_i - cnt_i;
  assign d_narrow = cmp_i[WW-1:0] - cnt_i[WW-1:0];
  assign parked   = &cmp_i;

  always_comb begin
    if (parked)        due_o = 1'b0;
    else if (narrow_i) due_o = d_narrow[WW-1] | (d_narrow == '0);
    else               due_o = d_wide[CW-1] | (d_wide == '0);
  end
endmodule

// File: rtl/ptimer_core.sv
`timescale 1ns/1ps
module ptimer_core
  import ptimer_pkg::*;
#(
  parameter int WW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2*WW-1:0] cnt_i,
  input  logic            gen_i,
  input  logic [31:0]     cfg_i,
  input  logic            cfg_we_i,
  input  logic [31:0]     cfg_wdata_i,
  input  logic            lo_we_i,
  input  logic            hi_we_i,
  input  logic [WW-1:0]   wdata_i,
  input  logic            due_i,
  output logic [2*WW-1:0] cmp_o,
  output logic            irq_o
);
  localparam int CW = 2 * WW;

  logic [CW-1:0] cmp_q, cmp_d, per_q, per_d;
  logic          wrap_q, wrap_d, pdue_q, pdue_d, irq_q, irq_d;
  logic          narrow, periodic, setv, int_en, any_wr, st_en;

  assign narrow   = cfg_i[CFG_NARROW];
  assign periodic = cfg_i[CFG_PERIODIC];
  assign setv     = cfg_i[CFG_SETVAL];
  assign int_en   = cfg_i[CFG_INT_EN];
  assign any_wr   = cfg_we_i | lo_we_i | hi_we_i;
  assign st_en    = any_wr | gen_i | irq_q;

  always_comb begin
    cmp_d  = cmp_q;
    per_d  = per_q;
    wrap_d = wrap_q;
    pdue_d = pdue_q;
    irq_d  = 1'b0;
    if (any_wr) begin
      pdue_d = 1'b0;
      if (cfg_we_i) begin
        wrap_d = 1'b0;
        if (cfg_wdata_i[CFG_NARROW]) begin
          cmp_d[CW-1:WW] = '0;
          per_d[CW-1:WW] = '0;
        end
      end
      if (lo_we_i) begin
        if (!periodic || setv) begin
          cmp_d[WW-1:0] = wdata_i;
          wrap_d = !periodic && narrow && (wdata_i < cnt_i[WW-1:0]);
        end
        if (periodic)
          per_d[WW-1:0] = narrow ? {1'b0, wdata_i[WW-2:0]} : wdata_i;
      end
      if (hi_we_i && !narrow) begin
        if (!periodic || setv) cmp_d[CW-1:WW] = wdata_i;
        else                   per_d[CW-1:WW] = {1'b0, wdata_i[WW-2:0]};
      end
    end else if (gen_i) begin
      pdue_d = due_i;
      if (wrap_q) begin
        if (cnt_i[WW-1:0] < cmp_q[WW-1:0]) wrap_d = 1'b0;
      end else begin
        irq_d = due_i && !pdue_q && int_en;
      end
      if (periodic && due_i && (per_q != '0)) begin
        if (narrow) cmp_d = {{WW{1'b0}}, cmp_q[WW-1:0] + per_q[WW-1:0]};
        else        cmp_d = cmp_q + per_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '1;
      per_q  <= '0;
      wrap_q <= 1'b0;
      pdue_q <= 1'b0;
      irq_q  <= 1'b0;
    end else if (st_en) begin
      cmp_q  <= cmp_d;
      per_q  <= per_d;
      wrap_q <= wrap_d;
      pdue_q <= pdue_d;
      irq_q  <= irq_d;
    end
  end

  assign cmp_o = cmp_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/ptimer_chan.sv
`timescale 1ns/1ps
module ptimer_chan
  import ptimer_pkg::*;
#(
  parameter int WW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2*WW-1:0] cnt_i,
  input  logic            gen_i,
  input  logic            cfg_we_i,
  input  logic            cmp_lo_we_i,
  input  logic            cmp_hi_we_i,
  input  logic [WW-1:0]   wdata_i,
  output logic [31:0]     cfg_o,
  output logic [2*WW-1:0] cmp_o,
  output logic            irq_o
);
  logic [31:0]     cfg_w;
  logic [2*WW-1:0] cmp_w;
  logic            due_w;
  logic [31:0]     cfg_wdata;

  assign cfg_wdata = 32'(wdata_i);

  ptimer_cfg u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .we_i         (cfg_we_i),
    .wdata_i      (cfg_wdata),
    .clr_setval_i (cmp_lo_we_i | cmp_hi_we_i),
    .cfg_o        (cfg_w)
  );

  ptimer_dist #(.WW(WW)) u_dist (
    .cmp_i    (cmp_w),
    .cnt_i    (cnt_i),
    .narrow_i (cfg_w[CFG_NARROW]),
    .due_o    (due_w)
  );

  ptimer_core #(.WW(WW)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_i       (cnt_i),
    .gen_i       (gen_i),
    .cfg_i       (cfg_w),
    .cfg_we_i    (cfg_we_i),
    .cfg_wdata_i (cfg_wdata),
    .lo_we_i     (cmp_lo_we_i),
    .hi_we_i     (cmp_hi_we_i),
    .wdata_i     (wdata_i),
    .due_i       (due_w),
    .cmp_o       (cmp_w),
    .irq_o       (irq_o)
  );

  assign cfg_o = cfg_w;
  assign cmp_o = cmp_w;
endmodule

// File: rtl/ptimer_chan_chk.sv
`timescale 1ns/1ps
module ptimer_chan_chk #(
  parameter int WW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            gen_i,
  input logic            cfg_we_i,
  input logic            cmp_lo_we_i,
  input logic            cmp_hi_we_i,
  input logic [31:0]     cfg_o,
  input logic [2*WW-1:0] cmp_o,
  input logic            irq_o
);
  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  p_gen_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_i |=> !irq_o);

  p_inten_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_o[2] |=> !irq_o);

  p_setval_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_lo_we_i || cmp_hi_we_i) |=> !cfg_o[6]);

  p_narrow_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[8] |-> (cmp_o[2*WW-1:WW] == '0));

  p_oneshot_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_o[3] && !cfg_we_i && !cmp_lo_we_i && !cmp_hi_we_i) |=> $stable(cmp_o));
endmodule

bind ptimer_chan ptimer_chan_chk #(.WW(WW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .gen_i       (gen_i),
  .cfg_we_i    (cfg_we_i),
  .cmp_lo_we_i (cmp_lo_we_i),
  .cmp_hi_we_i (cmp_hi_we_i),
  .cfg_o       (cfg_o),
  .cmp_o       (cmp_o),
  .irq_o       (irq_o)
);

// File: tb/ptimer_chan_test.sv
`timescale 1ns/1ps
module ptimer_chan_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] cnt;
  logic        gen, cfg_we, lo_we, hi_we;
  logic [31:0] wdata;
  logic [31:0] cfg_o;
  logic [63:0] cmp_o;
  logic        irq_o;
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  ptimer_chan uut (
    .clk (clk), .rst_n (rst_n), .cnt_i (cnt), .gen_i (gen),
    .cfg_we_i (cfg_we), .cmp_lo_we_i (lo_we), .cmp_hi_we_i (hi_we),
    .wdata_i (wdata), .cfg_o (cfg_o), .cmp_o (cmp_o), .irq_o (irq_o)
  );

  typedef struct packed {
    logic [63:0] cnt;
    logic        irq;
    logic [63:0] cmp;
  } vec_t;

  // periodic run: comparator 100, period 100
  localparam vec_t VEC [11] = '{
    '{64'd99,  1'b0, 64'd100},
    '{64'd100, 1'b1, 64'd200},
    '{64'd101, 1'b0, 64'd200},
    '{64'd250, 1'b1, 64'd300},
    '{64'd251, 1'b0, 64'd300},
    '{64'd650, 1'b1, 64'd400},
    '{64'd650, 1'b0, 64'd500},
    '{64'd650, 1'b0, 64'd600},
    '{64'd650, 1'b0, 64'd700},
    '{64'd650, 1'b0, 64'd700},
    '{64'd700, 1'b1, 64'd800}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cnt = '0; gen = 1'b0;
    cfg_we = 1'b0; lo_we = 1'b0; hi_we = 1'b0; wdata = '0;
    #9;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [31:0] v);
    cfg_we = 1'b1; wdata = v; step(); cfg_we = 1'b0;
  endtask
  task automatic wr_lo(input logic [31:0] v);
    lo_we = 1'b1; wdata = v; step(); lo_we = 1'b0;
  endtask
  task automatic wr_hi(input logic [31:0] v);
    hi_we = 1'b1; wdata = v; step(); hi_we = 1'b0;
  endtask
  task automatic tick(input logic [63:0] c);
    gen = 1'b1; cnt = c; step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1 cfg reset", 64'(cfg_o), 64'h30);
    chk("R1 cmp reset", cmp_o, '1);
    chk("R1 irq reset", 64'(irq_o), 64'd0);
    wr_cfg(32'h04);
    tick(64'd5);
    chk("R1 all-ones never fires", 64'(irq_o), 64'd0);

    // R2/R3 write mask and narrow truncation
    do_reset();
    wr_cfg(32'hFFFF_FFFF);
    chk("R2 cfg mask", 64'(cfg_o), 64'h7F7C);
    chk("R3 narrow truncates cmp", cmp_o, 64'h0000_0000_FFFF_FFFF);

    // periodic table walk (R4 R5 R6 R10)
    do_reset();
    wr_cfg(32'h4C); wr_hi(32'h0); wr_cfg(32'h4C); wr_lo(32'd100);
    chk("R5 setval cleared", 64'(cfg_o), 64'h3C);
    chk("R4 setval load", cmp_o, 64'd100);
    foreach (VEC[i]) begin
      tick(VEC[i].cnt);
      chk($sformatf("R6 R10 vec%0d irq", i), 64'(irq_o), 64'(VEC[i].irq));
      chk($sformatf("R6 vec%0d cmp", i), cmp_o, VEC[i].cmp);
    end

    // R4 periodic writes without setval go to the period, high half clamped
    do_reset();
    wr_cfg(32'h4C); wr_hi(32'h0); wr_cfg(32'h4C); wr_lo(32'd10);
    wr_lo(32'h8000_0005);
    chk("R4 period-only low write", cmp_o, 64'd10);
    tick(64'd10);
    chk("R6 wide reload irq", 64'(irq_o), 64'd1);
    chk("R4 wide period low", cmp_o, 64'h0000_0000_8000_000F);
    gen = 1'b0;
    wr_hi(32'hFFFF_FFFF);
    chk("R4 period-only high write", cmp_o, 64'h0000_0000_8000_000F);
    tick(64'h0000_0000_8000_000F);
    chk("R4 high clamp reload", cmp_o, 64'h8000_0000_0000_0014);

    // R6 narrow periodic wrap and clamp, R3 high write ignored
    do_reset();
    wr_cfg(32'h14C); wr_lo(32'hFFFF_FFF0);
    tick(64'h0000_0000_FFFF_FFF0);
    chk("R6 narrow irq", 64'(irq_o), 64'd1);
    chk("R6 narrow wrap add", cmp_o, 64'h0000_0000_7FFF_FFE0);
    gen = 1'b0;
    wr_hi(32'h1234);
    chk("R3 narrow high ignored", cmp_o, 64'h0000_0000_7FFF_FFE0);

    // R7 R9 one-shot wide, enable gating
    do_reset();
    wr_cfg(32'h04); wr_hi(32'h0); wr_lo(32'd50);
    gen = 1'b0; cnt = 64'd50; step();
    chk("R9 gen low no irq", 64'(irq_o), 64'd0);
    tick(64'd50);
    chk("R7 one-shot fires", 64'(irq_o), 64'd1);
    tick(64'd51);
    chk("R10 single pulse", 64'(irq_o), 64'd0);
    chk("R7 cmp held", cmp_o, 64'd50);
    gen = 1'b0;
    wr_cfg(32'h00); wr_lo(32'd60);
    tick(64'd60);
    chk("R9 int enable off", 64'(irq_o), 64'd0);
    gen = 1'b0;
    wr_cfg(32'h04); wr_lo(32'h10);
    tick(64'h100);
    chk("R7 behind target fires", 64'(irq_o), 64'd1);

    // R8 narrow one-shot wrap flag
    do_reset();
    wr_cfg(32'h104);
    cnt = 64'h100;
    wr_lo(32'h10);
    tick(64'h100);
    chk("R8 wrap suppresses", 64'(irq_o), 64'd0);
    tick(64'h105);
    chk("R8 still suppressed", 64'(irq_o), 64'd0);
    tick(64'h1_0000_0005);
    chk("R8 wrap seen", 64'(irq_o), 64'd0);
    tick(64'h1_0000_0010);
    chk("R8 real event", 64'(irq_o), 64'd1);
    tick(64'h1_0000_0011);
    chk("R8 after event", 64'(irq_o), 64'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule